// File: doc/BRIEF.md
# I2C Slave Address Matcher and Byte Receiver

This block is the receive front end of an I2C target. It oversamples the bus lines with the system clock and passes each through a synchronizer chain. From the synchronized levels it finds SCL edges and start and stop conditions. It shifts in bytes and decides whether the address phase selects this device. It recognizes three kinds of address: a 7-bit own address, a 10-bit own address sent as two bytes, and a programmable general-call address that counts only while its enable is set. When acknowledge is enabled, it pulls SDA low in the ninth clock slot. Received data bytes come out on a parallel bus with a one-cycle strobe. Level outputs report the match type and the direction bit.

The controller is one state machine with these states: `ST_OFF`, `ST_IDLE`, `ST_ADR_HI`, `ST_ADR_LO`, `ST_RX`, `ST_ACK_SET`, `ST_ACK_HOLD`, `ST_ACK_END` and `ST_IGNORE`.
- Dropping `enable` forces `ST_OFF` from any state. With `enable` high, `ST_OFF` moves to `ST_IDLE`.
- A start condition moves any enabled state to `ST_ADR_HI`. A stop condition moves any enabled state to `ST_IDLE`.
- After the eighth SCL rise, `ST_ADR_HI` goes to `ST_ACK_SET` on a match or a 10-bit upper-byte match. Otherwise it goes to `ST_IGNORE`.
- `ST_ADR_LO` goes to `ST_ACK_SET` on a low-byte match and to `ST_IGNORE` otherwise. `ST_RX` always goes to `ST_ACK_SET`.
- `ST_ACK_SET` goes to `ST_ACK_HOLD` on an SCL fall. `ST_ACK_HOLD` goes to `ST_ACK_END` on an SCL rise.
- `ST_ACK_END` goes, on an SCL fall, to the state chosen at the decision: `ST_ADR_LO`, `ST_RX` or `ST_IGNORE`.

Top module: `i2c_addr_slave`

## Requirements
- R1: After reset, and whenever `enable` is low, the block acknowledges nothing, keeps `sda_oe` and `addressed` low, and gives no `stop_pulse`. All outputs are zero after reset.
- R2: A stop condition (SDA rising while SCL is high) gives exactly one `stop_pulse` cycle. It clears `addressed`, `gen_call` and `rw_bit`.
- R3: Bytes are taken most significant bit first, one bit per SCL rising edge. Every data byte that follows a successful address phase appears on `rx_data` with `rx_valid` high for exactly one cycle.
- R4: With `ten_bit_mode`=0, a first byte whose bits [7:1] equal `own_addr[6:0]` sets `addressed`, and bit 0 of that byte is copied to `rw_bit`. If bit 0 is 1 (read), the bytes that follow give no `rx_valid`.
- R5: When `ack_en`=1, `sda_oe` is high from the SCL fall after the eighth rise of an accepted byte until the SCL fall after the ninth rise. When `ack_en`=0, SDA stays released, but the flags and strobes behave the same. While `enable` stays high, `sda_oe` changes only while synchronized SCL is low.
- R6: With `ten_bit_mode`=1, the first byte 11110 `own_addr[9:8]` 0 is acknowledged without setting `addressed`. A second byte equal to `own_addr[7:0]` then sets `addressed`. Any other second byte is not acknowledged.
- R7: With `ten_bit_mode`=1, a first byte 11110 `own_addr[9:8]` 1 sets `addressed` with `rw_bit`=1 only if a full 10-bit write match has happened since the last stop. Otherwise it is not acknowledged.
- R8: With `gc_en`=1, a first byte with bits [7:1] equal to `gc_addr` and bit 0 equal to 0 sets both `addressed` and `gen_call`. This match takes priority over the own-address match. With `gc_en`=0 the general-call address is not recognized.
- R9: The address byte 01h is never acknowledged or matched, whatever `own_addr` and `gc_addr` hold.
- R10: After an address mismatch, the block leaves SDA released and gives no strobes until the next start condition.
- R11: A start condition (SDA falling while SCL is high), including a repeated start in the middle of a transfer, clears `addressed` and `gen_call` and begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Peripheral enable; low forces the idle, released state |
| ack_en | input | 1 | Allows the acknowledge to be driven in the ninth slot |
| ten_bit_mode | input | 1 | 1 selects 10-bit own-address matching |
| own_addr | input | 10 | Own address; bits [6:0] are used in 7-bit mode |
| gc_en | input | 1 | Enables the general-call match |
| gc_addr | input | 7 | Programmable general-call address |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain drive) |
| addressed | output | 1 | Address phase selected this device |
| gen_call | output | 1 | The match was the general-call address |
| rw_bit | output | 1 | Direction bit of the matched address |
| rx_data | output | 8 | Last received data byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| stop_pulse | output | 1 | One-cycle pulse on a stop condition |

## Verification
The bench builds the block with its default of a two-stage synchronizer. With bit phases of 20 system clocks, every SCL edge is seen well before the next SDA change. This spacing lets the open-drain bus model sample the acknowledge in the middle of the ninth high phase. Because the address, general-call and mode values are inputs rather than parameters, the same build reaches the corner cases: own address zero against the 01h byte, a general-call address that differs from 00h, and a 10-bit read that depends on a match made before a repeated start.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;

    localparam int BYTE_W    = 8;
    localparam int BIT_CNT_W = $clog2(BYTE_W);
    localparam int OWN_W     = 10;
    localparam int GC_W      = 7;
    localparam int TAG_W     = 5;

    localparam logic [TAG_W-1:0]  TEN_BIT_TAG = 5'b11110;
    localparam logic [BYTE_W-1:0] START_BYTE  = 8'h01;

    typedef enum logic [3:0] {
        ST_OFF,
        ST_IDLE,
        ST_ADR_HI,
        ST_ADR_LO,
        ST_RX,
        ST_ACK_SET,
        ST_ACK_HOLD,
        ST_ACK_END,
        ST_IGNORE
    } slv_state_e;

    typedef struct packed {
        logic hit7;
        logic gc_hit;
        logic hi10;
        logic lo10;
        logic start_byte;
    } match_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic chain [STAGES];

    genvar i;
    for (i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[0] <= 1'b1;
                else        chain[0] <= d;
            end
        end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[i] <= 1'b1;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_cond,
    output logic stop_cond
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_lvl    = scl_s;
    assign sda_lvl    = sda_s;
    assign scl_rise   = scl_s & ~scl_q;
    assign scl_fall   = ~scl_s & scl_q;
    assign start_cond = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_cond  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
    import i2c_slv_pkg::*;
(
    input  logic [BYTE_W-1:0] cur_byte,
    input  logic              ten_bit_mode,
    input  logic [OWN_W-1:0]  own_addr,
    input  logic              gc_en,
    input  logic [GC_W-1:0]   gc_addr,
    output match_t            hit
);

    always_comb begin
        hit.hit7       = !ten_bit_mode && (cur_byte[BYTE_W-1:1] == own_addr[GC_W-1:0]);
        hit.gc_hit     = gc_en && !cur_byte[0] && (cur_byte[BYTE_W-1:1] == gc_addr);
        hit.hi10       = ten_bit_mode
                         && (cur_byte[BYTE_W-1:BYTE_W-TAG_W] == TEN_BIT_TAG)
                         && (cur_byte[2:1] == own_addr[OWN_W-1:BYTE_W]);
        hit.lo10       = ten_bit_mode && (cur_byte == own_addr[BYTE_W-1:0]);
        hit.start_byte = (cur_byte == START_BYTE);
    end

endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
    import i2c_slv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              ack_en,
    input  logic              scl_lvl,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_cond,
    input  logic              stop_cond,
    input  match_t            hit,
    output logic [BYTE_W-1:0] cur_byte,
    output logic              sda_oe,
    output logic              addressed,
    output logic              gen_call,
    output logic              rw_bit,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              stop_pulse
);

    slv_state_e state, nxt;
    slv_state_e ack_after, after_n;
    logic                 ack_want, want_n;
    logic [BIT_CNT_W-1:0] bit_cnt;
    logic [BYTE_W-1:0]    shreg;
    logic                 ten_armed;

    logic shifting, byte_done, go_ack;
    logic mark_addr, mark_gc, set_rw, arm_set, arm_clr, push;

    assign shifting  = (state == ST_ADR_HI) || (state == ST_ADR_LO) || (state == ST_RX);
    assign byte_done = shifting && scl_rise && (bit_cnt == BIT_CNT_W'(BYTE_W-1));
    assign cur_byte  = {shreg[BYTE_W-2:0], sda_lvl};

    // next-state and decision logic
    always_comb begin
        nxt       = state;
        go_ack    = 1'b0;
        after_n   = ST_IGNORE;
        mark_addr = 1'b0;
        mark_gc   = 1'b0;
        set_rw    = 1'b0;
        arm_set   = 1'b0;
        arm_clr   = 1'b0;
        push      = 1'b0;
        if (!enable) begin
            nxt = ST_OFF;
        end else if (start_cond) begin
            nxt = ST_ADR_HI;
        end else if (stop_cond) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_OFF:  nxt = ST_IDLE;
                ST_IDLE: nxt = ST_IDLE;
                ST_ADR_HI: begin
                    if (byte_done) begin
                        if (hit.start_byte) begin
                            nxt     = ST_IGNORE;
                            arm_clr = 1'b1;
                        end else if (hit.gc_hit) begin
                            go_ack    = 1'b1;
                            after_n   = ST_RX;
                            mark_addr = 1'b1;
                            mark_gc   = 1'b1;
                            arm_clr   = 1'b1;
                        end else if (hit.hit7) begin
                            go_ack    = 1'b1;
                            after_n   = cur_byte[0] ? ST_IGNORE : ST_RX;
                            mark_addr = 1'b1;
                            set_rw    = cur_byte[0];
                        end else if (hit.hi10 && !cur_byte[0]) begin
                            go_ack  = 1'b1;
                            after_n = ST_ADR_LO;
                        end else if (hit.hi10 && ten_armed) begin
                            go_ack    = 1'b1;
                            after_n   = ST_IGNORE;
                            mark_addr = 1'b1;
                            set_rw    = 1'b1;
                        end else begin
                            nxt     = ST_IGNORE;
                            arm_clr = 1'b1;
                        end
                    end
                end
                ST_ADR_LO: begin
                    if (byte_done) begin
                        if (hit.lo10) begin
                            go_ack    = 1'b1;
                            after_n   = ST_RX;
                            mark_addr = 1'b1;
                            arm_set   = 1'b1;
                        end else begin
                            nxt     = ST_IGNORE;
                            arm_clr = 1'b1;
                        end
                    end
                end
                ST_RX: begin
                    if (byte_done) begin
                        push    = 1'b1;
                        go_ack  = 1'b1;
                        after_n = ST_RX;
                    end
                end
                ST_ACK_SET:  if (scl_fall) nxt = ST_ACK_HOLD;
                ST_ACK_HOLD: if (scl_rise) nxt = ST_ACK_END;
                ST_ACK_END:  if (scl_fall) nxt = ack_after;
                ST_IGNORE:   nxt = ST_IGNORE;
                default:     nxt = ST_IDLE;
            endcase
            if (go_ack) nxt = ST_ACK_SET;
        end
    end

    assign want_n = ack_en;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_after  <= ST_IGNORE;
            ack_want   <= 1'b0;
            bit_cnt    <= '0;
            shreg      <= '0;
            ten_armed  <= 1'b0;
            sda_oe     <= 1'b0;
            addressed  <= 1'b0;
            gen_call   <= 1'b0;
            rw_bit     <= 1'b0;
            rx_data    <= '0;
            rx_valid   <= 1'b0;
            stop_pulse <= 1'b0;
        end else begin
            rx_valid   <= push;
            stop_pulse <= enable && stop_cond;
            sda_oe     <= ack_want && ((nxt == ST_ACK_HOLD) || (nxt == ST_ACK_END));

            if (go_ack) begin
                ack_want  <= want_n;
                ack_after <= after_n;
            end

            if (start_cond || (state == ST_ACK_END)) bit_cnt <= '0;
            else if (shifting && scl_rise)           bit_cnt <= bit_cnt + 1'b1;

            if (shifting && scl_rise) shreg <= cur_byte;

            if (!enable || start_cond || stop_cond) begin
                addressed <= 1'b0;
                gen_call  <= 1'b0;
                rw_bit    <= 1'b0;
            end else if (mark_addr) begin
                addressed <= 1'b1;
                gen_call  <= mark_gc;
                rw_bit    <= set_rw;
            end

            if (!enable || stop_cond) ten_armed <= 1'b0;
            else if (arm_set)         ten_armed <= 1'b1;
            else if (arm_clr)         ten_armed <= 1'b0;

            if (push) rx_data <= cur_byte;
        end
    end

    // R1
    off_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!sda_oe && !addressed));

    // R2
    stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |-> !addressed);

    // R3
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R3
    strobe_addressed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> addressed);

    // R5
    drive_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !$past(scl_lvl));

    // R5
    release_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sda_oe) && $past(enable)) |-> !$past(scl_lvl));

    // R8
    gc_implies_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gen_call |-> addressed);

    // R11
    start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && start_cond) |=> (state == ST_ADR_HI && !addressed));

endmodule

// File: rtl/i2c_addr_slave.sv
module i2c_addr_slave
    import i2c_slv_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              ack_en,
    input  logic              ten_bit_mode,
    input  logic [OWN_W-1:0]  own_addr,
    input  logic              gc_en,
    input  logic [GC_W-1:0]   gc_addr,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    output logic              addressed,
    output logic              gen_call,
    output logic              rw_bit,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              stop_pulse
);

    logic scl_s, sda_s;
    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_cond, stop_cond;
    logic [BYTE_W-1:0] cur_byte;
    match_t hit;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s)
    );

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s)
    );

    i2c_cond_detect u_cond (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_cond(start_cond), .stop_cond(stop_cond)
    );

    i2c_addr_match u_match (
        .cur_byte(cur_byte), .ten_bit_mode(ten_bit_mode), .own_addr(own_addr),
        .gc_en(gc_en), .gc_addr(gc_addr), .hit(hit)
    );

    i2c_slave_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .enable(enable), .ack_en(ack_en),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_cond(start_cond), .stop_cond(stop_cond),
        .hit(hit), .cur_byte(cur_byte),
        .sda_oe(sda_oe), .addressed(addressed), .gen_call(gen_call),
        .rw_bit(rw_bit), .rx_data(rx_data), .rx_valid(rx_valid),
        .stop_pulse(stop_pulse)
    );

endmodule

// File: tb/tb_i2c_addr_slave.sv
module tb_i2c_addr_slave;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n, enable, ack_en, ten_bit_mode, gc_en;
    logic [9:0] own_addr;
    logic [6:0] gc_addr;
    logic       scl_m, sda_m, sda_bus;
    logic       sda_oe, addressed, gen_call, rw_bit, rx_valid, stop_pulse;
    logic [7:0] rx_data;

    assign sda_bus = sda_m & ~sda_oe;

    i2c_addr_slave dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .ack_en(ack_en),
        .ten_bit_mode(ten_bit_mode), .own_addr(own_addr), .gc_en(gc_en),
        .gc_addr(gc_addr), .scl_in(scl_m), .sda_in(sda_bus),
        .sda_oe(sda_oe), .addressed(addressed), .gen_call(gen_call),
        .rw_bit(rw_bit), .rx_data(rx_data), .rx_valid(rx_valid),
        .stop_pulse(stop_pulse)
    );

    int total = 0;
    int bad = 0;
    int vcnt = 0;
    int scnt = 0;
    logic [7:0] vlog [16];
    bit finished = 1'b0;

    always @(negedge clk) begin
        if (rx_valid) begin
            vlog[vcnt % 16] = rx_data;
            vcnt = vcnt + 1;
        end
        if (stop_pulse) scnt = scnt + 1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (20) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq();
            scl_m = 1'b1; wq();
            scl_m = 1'b0; wq();
        end
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        acked = !sda_bus;
        wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic t_reset();
        chk("R1 reset sda_oe", sda_oe, 0);
        chk("R1 reset addressed", addressed, 0);
        chk("R1 reset rx_data", rx_data, 0);
        chk("R1 reset strobes", vcnt + scnt, 0);
    endtask

    task automatic t_disabled();
        logic a;
        int s0;
        enable = 1'b0; own_addr = 10'h052; ten_bit_mode = 1'b0;
        s0 = scnt;
        bus_start(); send_byte(8'hA4, a);
        chk("R1 no ack while disabled", a, 0);
        chk("R1 not addressed while disabled", addressed, 0);
        bus_stop();
        chk("R1 no stop pulse while disabled", scnt - s0, 0);
        enable = 1'b1; wq();
    endtask

    task automatic t_7bit_write();
        logic a;
        int v0, s0;
        bus_start(); send_byte(8'hA4, a);
        chk("R4 7-bit ack", a, 1);
        chk("R4 addressed", addressed, 1);
        chk("R4 rw write", rw_bit, 0);
        chk("R8 no gen_call", gen_call, 0);
        v0 = vcnt;
        send_byte(8'h3C, a);
        chk("R5 data ack", a, 1);
        send_byte(8'hC1, a);
        chk("R3 strobe count", vcnt - v0, 2);
        chk("R3 first byte", vlog[v0 % 16], 8'h3C);
        chk("R3 second byte", vlog[(v0 + 1) % 16], 8'hC1);
        s0 = scnt;
        bus_stop();
        chk("R2 one stop pulse", scnt - s0, 1);
        chk("R2 addressed cleared", addressed, 0);
    endtask

    task automatic t_7bit_read();
        logic a;
        int v0;
        bus_start(); send_byte(8'hA5, a);
        chk("R4 read ack", a, 1);
        chk("R4 read addressed", addressed, 1);
        chk("R4 rw read", rw_bit, 1);
        v0 = vcnt;
        send_byte(8'h77, a);
        chk("R4 no strobe after read", vcnt - v0, 0);
        bus_stop();
        chk("R2 rw cleared", rw_bit, 0);
    endtask

    task automatic t_mismatch();
        logic a;
        int v0;
        bus_start(); send_byte(8'hA6, a);
        chk("R10 mismatch nack", a, 0);
        chk("R10 not addressed", addressed, 0);
        v0 = vcnt;
        send_byte(8'h5A, a);
        chk("R10 data nack", a, 0);
        chk("R10 no strobe", vcnt - v0, 0);
        bus_stop();
    endtask

    task automatic t_noack();
        logic a;
        int v0;
        ack_en = 1'b0;
        bus_start(); send_byte(8'hA4, a);
        chk("R5 address not acked", a, 0);
        chk("R5 still addressed", addressed, 1);
        v0 = vcnt;
        send_byte(8'h11, a);
        chk("R5 data not acked", a, 0);
        chk("R5 strobe kept", vcnt - v0, 1);
        chk("R3 byte with ack off", vlog[v0 % 16], 8'h11);
        bus_stop();
        ack_en = 1'b1;
    endtask

    task automatic t_10bit();
        logic a;
        int v0;
        ten_bit_mode = 1'b1; own_addr = 10'h2B7;
        bus_start(); send_byte(8'hF4, a);
        chk("R6 high byte ack", a, 1);
        chk("R6 not yet addressed", addressed, 0);
        send_byte(8'hB7, a);
        chk("R6 low byte ack", a, 1);
        chk("R6 addressed", addressed, 1);
        v0 = vcnt;
        send_byte(8'h9E, a);
        chk("R3 10-bit data", vlog[v0 % 16], 8'h9E);
        bus_rstart();
        chk("R11 repeated start clears", addressed, 0);
        send_byte(8'hF5, a);
        chk("R7 armed read ack", a, 1);
        chk("R7 armed read addressed", addressed, 1);
        chk("R7 rw read", rw_bit, 1);
        bus_stop();
    endtask

    task automatic t_10bit_bad();
        logic a;
        bus_start(); send_byte(8'hF4, a);
        send_byte(8'hB6, a);
        chk("R6 wrong low byte nack", a, 0);
        chk("R6 wrong low byte unaddressed", addressed, 0);
        bus_stop();
        bus_start(); send_byte(8'hF5, a);
        chk("R7 unarmed read nack", a, 0);
        chk("R7 unarmed read unaddressed", addressed, 0);
        bus_stop();
        ten_bit_mode = 1'b0; own_addr = 10'h052;
    endtask

    task automatic t_gc();
        logic a;
        int v0;
        gc_addr = 7'h00; gc_en = 1'b1;
        bus_start(); send_byte(8'h00, a);
        chk("R8 gc ack", a, 1);
        chk("R8 gc flag", gen_call, 1);
        chk("R8 gc addressed", addressed, 1);
        v0 = vcnt;
        send_byte(8'h06, a);
        chk("R8 gc data", vlog[v0 % 16], 8'h06);
        bus_stop();
        chk("R2 gc cleared", gen_call, 0);
        gc_en = 1'b0;
        bus_start(); send_byte(8'h00, a);
        chk("R8 gc disabled nack", a, 0);
        chk("R8 gc disabled flag", gen_call, 0);
        bus_stop();
        gc_addr = 7'h3A; gc_en = 1'b1;
        bus_start(); send_byte(8'h74, a);
        chk("R8 programmed gc ack", a, 1);
        chk("R8 programmed gc flag", gen_call, 1);
        bus_stop();
    endtask

    task automatic t_start_byte();
        logic a;
        own_addr = 10'h000; gc_addr = 7'h00; gc_en = 1'b1;
        bus_start(); send_byte(8'h01, a);
        chk("R9 start byte nack", a, 0);
        chk("R9 start byte unaddressed", addressed, 0);
        bus_stop();
        own_addr = 10'h052; gc_en = 1'b0;
    endtask

    task automatic t_rstart_mid();
        logic a;
        bus_start(); send_byte(8'hA4, a);
        send_byte(8'h10, a);
        chk("R11 addressed before restart", addressed, 1);
        bus_rstart();
        chk("R11 cleared by restart", addressed, 0);
        send_byte(8'hA6, a);
        chk("R11 new address phase nack", a, 0);
        bus_rstart();
        send_byte(8'hA5, a);
        chk("R11 new address phase read", rw_bit, 1);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; enable = 1'b0; ack_en = 1'b1; ten_bit_mode = 1'b0;
        own_addr = 10'h052; gc_en = 1'b0; gc_addr = 7'h00;
        scl_m = 1'b1; sda_m = 1'b1;
        repeat (5) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        wq();
        t_reset();
        t_disabled();
        t_7bit_write();
        t_7bit_read();
        t_mismatch();
        t_noack();
        t_10bit();
        t_10bit_bad();
        t_gc();
        t_start_byte();
        t_rstart_mid();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule